// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Latch and Pin Read Paths

This block is one eight-bit general-purpose I/O port of a small microcontroller. An output latch drives the pins. Each pin is modelled as the latch bit ANDed with whatever the outside world drives onto it. The outside world can pull a pin low. It cannot pull a pin high while its latch bit is 0. A pin therefore works as an input only while its latch bit holds 1, and the latch resets to all ones so that every pin starts as a usable input.

The processor side offers byte writes and four single-bit operations: set, clear, complement and copy-from-data. Reads come in two kinds, chosen by a select line. A plain read returns the pin levels after a two-flop synchronizer. A latch read returns the output latch. Bit operations never use the pins: they read the latch, alter one bit and write the latch back. A pin that is held low from outside therefore cannot be copied into the latch by accident.

Addressing is bit-granular:
- The port's byte address, `BASE_ADDR`, is also the bit address of pin 0.
- Pin n sits at `BASE_ADDR + n`.
- Byte operations decode only `BASE_ADDR`.
- Bit operations and bit reads decode the eight-entry window `BASE_ADDR` to `BASE_ADDR + 7`.

A small controller sequences every latch update through three states:
- `ST_IDLE`: accepts a request. For a bit operation it reads the latch into a work register and takes the transition `IDLE->MODIFY`. For a byte write it loads the write data and takes the transition `IDLE->COMMIT`.
- `ST_MODIFY`: alters the addressed bit of the work register and takes `MODIFY->COMMIT`.
- `ST_COMMIT`: writes the work register into the latch, which drives the pins from the next cycle, and takes `COMMIT->IDLE`.

While the controller is not in `ST_IDLE`, the block raises busy and drops any new request.

Top module: `qb_port`

## Requirements
- R1: After reset the latch holds FFh, so pin_out is FFh, bus_busy is 0, and a latch read at the byte address returns FFh.
- R2: A byte write (bus_op = 1) at exactly BASE_ADDR loads bus_wdata into the latch. pin_out shows the new value two clock edges after the request edge.
- R3: A bit operation at BASE_ADDR + n changes only latch bit n, where n is bus_addr[2:0] and bit 0 is the LSB. The operations are set (bus_op = 2), clear (3), complement (4) and copy of bus_wdata[0] (5). The other seven bits keep their values, and pin_out shows the result three edges after the request edge.
- R4: Bit operations read the latch, never the pins. Latch bits whose pins are pulled low from outside keep their stored 1 through any bit operation on another bit.
- R5: With bus_rd_latch = 0, a byte read at BASE_ADDR returns pin_out & pin_in. The value is delayed by a two-flop synchronizer, so a change in pin_in appears after the second clock edge and not after the first.
- R6: With bus_rd_latch = 1, a byte read at BASE_ADDR returns the latch contents, whatever the pin levels are.
- R7: bus_rbit returns bit bus_addr[2:0] of the chosen source (pins or latch, as set by bus_rd_latch) when the address is inside the bit window.
- R8: Addresses outside BASE_ADDR to BASE_ADDR + 7 give bus_hit = 0 and read as bus_rdata = 0 and bus_rbit = 0, and writes to them leave the latch unchanged. Byte reads and byte writes at BASE_ADDR + 1 to + 7 are ignored in the same way: they read as 0 and leave the latch unchanged.
- R9: Once a bit operation is accepted, bus_busy is 1 for exactly two cycles (`ST_MODIFY`, then `ST_COMMIT`). Any request presented while bus_busy is 1 is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte or bit address from the processor |
| bus_op | input | 3 | 0 none, 1 byte write, 2 set bit, 3 clear bit, 4 complement bit, 5 copy bus_wdata[0] into bit; 6 and 7 act as none |
| bus_wdata | input | 8 | Byte write data; bit 0 is the source for the copy-bit operation |
| bus_rd_latch | input | 1 | Read source: 1 = latch, 0 = synchronized pins |
| bus_hit | output | 1 | Address lies in the port's bit window |
| bus_busy | output | 1 | Latch update in progress; requests are dropped |
| bus_rdata | output | 8 | Byte read data, 0 unless the address is BASE_ADDR |
| bus_rbit | output | 1 | Bit read data, 0 outside the bit window |
| pin_out | output | 8 | Output latch driving the pins |
| pin_in | input | 8 | External drive on the pins (pin level = pin_out & pin_in) |

## Verification
The main vector walk runs byte writes and all four bit operations against a changing latch. Pin drives are chosen so that pins and latch disagree: all-high pins, lower-half-low pins and upper-half-low pins. A read that wrongly takes the pins for a bit operation, or wrongly takes the latch for a plain read, then gives a visibly different byte. Writes to a neighbouring byte address, to the next bit window and to a bit address with a byte operation separate a correct decoder from one that compares too few address bits. The copy-bit operation is tried with a data word whose bit 0 differs from its other bits, which exposes a wrong choice of source bit. Directed cases count the exact busy and synchronizer cycles, and they present a second request during busy to show that it is dropped.

// File: rtl/qb_port_pkg.sv
package qb_port_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WRBYTE = 3'd1,
        OP_SETBIT = 3'd2,
        OP_CLRBIT = 3'd3,
        OP_CPLBIT = 3'd4,
        OP_MOVBIT = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } port_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MODIFY = 2'd1,
        ST_COMMIT = 2'd2
    } rmw_state_e;

    function automatic logic is_bit_op(input port_op_e op);
        return (op == OP_SETBIT) || (op == OP_CLRBIT) ||
               (op == OP_CPLBIT) || (op == OP_MOVBIT);
    endfunction

    function automatic logic alter_bit(input port_op_e op,
                                       input logic     cur,
                                       input logic     src);
        logic res;
        unique case (op)
            OP_SETBIT: res = 1'b1;
            OP_CLRBIT: res = 1'b0;
            OP_CPLBIT: res = ~cur;
            OP_MOVBIT: res = src;
            default:   res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/qb_addr_dec.sv
module qb_addr_dec #(
    parameter int unsigned            AW        = 8,
    parameter int unsigned            IDXW      = 3,
    parameter logic [AW-1:0]          BASE_ADDR = 8'h80
) (
    input  logic [AW-1:0]   addr,
    output logic            byte_hit,
    output logic            bit_hit,
    output logic [IDXW-1:0] bit_idx
);
    localparam logic [AW-IDXW-1:0] WIN_TAG = BASE_ADDR[AW-1:IDXW];

    always_comb begin
        byte_hit = (addr == BASE_ADDR);
        bit_hit  = (addr[AW-1:IDXW] == WIN_TAG);
        bit_idx  = addr[IDXW-1:0];
    end

    // R8
    always_comb begin
        byte_in_window_chk: assert (!byte_hit || bit_hit)
            else $error("byte match outside bit window");
    end
endmodule

// File: rtl/qb_sync2.sv
module qb_sync2 #(
    parameter int unsigned      WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RESET_VAL;
            stage2_q <= RESET_VAL;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R5
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (dout == $past(din, 2)))
        else $error("synchronizer latency is not two cycles");
endmodule

// File: rtl/qb_rmw_ctrl.sv
module qb_rmw_ctrl
    import qb_port_pkg::*;
#(
    parameter int unsigned      WIDTH     = 8,
    parameter int unsigned      IDXW      = 3,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  port_op_e         req_op,
    input  logic             byte_hit,
    input  logic             bit_hit,
    input  logic [IDXW-1:0]  bit_idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic             busy
);
    rmw_state_e       st_q, st_nx;
    port_op_e         op_q;
    logic [IDXW-1:0]  idx_q;
    logic             src_q;
    logic [WIDTH-1:0] work_q;
    logic             take_byte;
    logic             take_bit;

    always_comb begin
        take_byte = (st_q == ST_IDLE) && byte_hit && (req_op == OP_WRBYTE);
        take_bit  = (st_q == ST_IDLE) && bit_hit  && is_bit_op(req_op);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (take_bit)       st_nx = ST_MODIFY;
                else if (take_byte) st_nx = ST_COMMIT;
            end
            ST_MODIFY: st_nx = ST_COMMIT;
            ST_COMMIT: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (st_q != ST_IDLE);
    end

    // datapath: read latch, modify, commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NOP;
            idx_q   <= '0;
            src_q   <= 1'b0;
            work_q  <= RESET_VAL;
            latch_q <= RESET_VAL;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (take_bit) begin
                        op_q   <= req_op;
                        idx_q  <= bit_idx;
                        src_q  <= wdata[0];
                        work_q <= latch_q;
                    end else if (take_byte) begin
                        op_q   <= OP_WRBYTE;
                        work_q <= wdata;
                    end
                end
                ST_MODIFY: begin
                    work_q[idx_q] <= alter_bit(op_q, work_q[idx_q], src_q);
                end
                ST_COMMIT: begin
                    latch_q <= work_q;
                end
                default: ;
            endcase
        end
    end

    // R9
    modify_then_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MODIFY) |=> (st_q == ST_COMMIT))
        else $error("MODIFY not followed by COMMIT");

    // R9
    busy_drops_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COMMIT) |=> (st_q == ST_IDLE))
        else $error("request accepted while busy");

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_COMMIT) |=> $stable(latch_q))
        else $error("latch changed outside COMMIT");

    // R3
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COMMIT && op_q != OP_WRBYTE) |=>
            ($countones(latch_q ^ $past(latch_q)) <= 1))
        else $error("bit operation changed more than one latch bit");
endmodule

// File: rtl/qb_port.sv
module qb_port
    import qb_port_pkg::*;
#(
    parameter int unsigned      WIDTH     = 8,
    parameter int unsigned      AW        = 8,
    parameter logic [AW-1:0]    BASE_ADDR = 8'h80,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [2:0]       bus_op,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_rd_latch,
    output logic             bus_hit,
    output logic             bus_busy,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             bus_rbit,
    output logic [WIDTH-1:0] pin_out,
    input  logic [WIDTH-1:0] pin_in
);
    localparam int unsigned IDXW = $clog2(WIDTH);

    logic             byte_hit;
    logic             bit_hit;
    logic [IDXW-1:0]  bit_idx;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pin_level;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] rd_src;
    port_op_e         op_in;

    assign op_in = port_op_e'(bus_op);

    qb_addr_dec #(
        .AW        (AW),
        .IDXW      (IDXW),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr     (bus_addr),
        .byte_hit (byte_hit),
        .bit_hit  (bit_hit),
        .bit_idx  (bit_idx)
    );

    qb_rmw_ctrl #(
        .WIDTH     (WIDTH),
        .IDXW      (IDXW),
        .RESET_VAL (RESET_VAL)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_op   (op_in),
        .byte_hit (byte_hit),
        .bit_hit  (bit_hit),
        .bit_idx  (bit_idx),
        .wdata    (bus_wdata),
        .latch_q  (latch_q),
        .busy     (bus_busy)
    );

    assign pin_level = latch_q & pin_in;

    qb_sync2 #(
        .WIDTH     (WIDTH),
        .RESET_VAL (RESET_VAL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_level),
        .dout  (pin_sync)
    );

    always_comb begin
        rd_src    = bus_rd_latch ? latch_q : pin_sync;
        bus_hit   = bit_hit;
        bus_rdata = byte_hit ? rd_src : '0;
        bus_rbit  = bit_hit ? rd_src[bit_idx] : 1'b0;
        pin_out   = latch_q;
    end

    // R8
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_hit |-> (bus_rdata == '0 && !bus_rbit))
        else $error("read data on address miss");

    // R6
    latch_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_hit && bus_rd_latch) |-> (bus_rdata == pin_out))
        else $error("latch read differs from pin_out");
endmodule

// File: tb/qb_port_tb.sv
`timescale 1ns/1ps
module qb_port_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr;
    logic [2:0] bus_op;
    logic [7:0] bus_wdata;
    logic       bus_rd_latch;
    logic       bus_hit;
    logic       bus_busy;
    logic [7:0] bus_rdata;
    logic       bus_rbit;
    logic [7:0] pin_out;
    logic [7:0] pin_in;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    qb_port u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_op       (bus_op),
        .bus_wdata    (bus_wdata),
        .bus_rd_latch (bus_rd_latch),
        .bus_hit      (bus_hit),
        .bus_busy     (bus_busy),
        .bus_rdata    (bus_rdata),
        .bus_rbit     (bus_rbit),
        .pin_out      (pin_out),
        .pin_in       (pin_in)
    );

    // {op, addr, wdata, pin drive, expected latch}
    localparam int NVEC = 15;
    localparam logic [34:0] VEC [0:NVEC-1] = '{
        {3'd1, 8'h80, 8'hA5, 8'hFF, 8'hA5},
        {3'd2, 8'h81, 8'h00, 8'hFF, 8'hA7},
        {3'd3, 8'h87, 8'h00, 8'hFF, 8'h27},
        {3'd4, 8'h83, 8'h00, 8'hFF, 8'h2F},
        {3'd5, 8'h86, 8'h01, 8'hFF, 8'h6F},
        {3'd1, 8'h80, 8'hFF, 8'h0F, 8'hFF},
        {3'd3, 8'h80, 8'h00, 8'h0F, 8'hFE},
        {3'd4, 8'h80, 8'h00, 8'hF0, 8'hFF},
        {3'd1, 8'h90, 8'h00, 8'hF0, 8'hFF},
        {3'd1, 8'h80, 8'h00, 8'hFF, 8'h00},
        {3'd2, 8'h88, 8'h00, 8'hFF, 8'h00},
        {3'd1, 8'h81, 8'hFF, 8'hFF, 8'h00},
        {3'd5, 8'h84, 8'h01, 8'hFF, 8'h10},
        {3'd5, 8'h84, 8'hFE, 8'hFF, 8'h00},
        {3'd4, 8'h87, 8'h00, 8'h3C, 8'h80}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [7:0] addr, input logic [7:0] wd);
        @(negedge clk);
        bus_op    = op;
        bus_addr  = addr;
        bus_wdata = wd;
        @(negedge clk);
        bus_op = 3'd0;
        while (bus_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic read_byte(input logic src_latch, output logic [7:0] val);
        bus_addr     = 8'h80;
        bus_rd_latch = src_latch;
        #1;
        val = bus_rdata;
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        rst_n = 1'b0; bus_addr = 8'h00; bus_op = 3'd0; bus_wdata = 8'h00;
        bus_rd_latch = 1'b0; pin_in = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 pin_out", pin_out, 8'hFF);
        check("R1 busy", {7'd0, bus_busy}, 8'h00);
        read_byte(1'b1, rv);
        check("R1 latch read", rv, 8'hFF);

        // R2 R3 R4 R5 R6 R8 vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] v_op;
            logic [7:0] v_addr, v_wd, v_pins, v_exp;
            {v_op, v_addr, v_wd, v_pins, v_exp} = VEC[i];
            @(negedge clk);
            pin_in = v_pins;
            run_op(v_op, v_addr, v_wd);
            check($sformatf("R2 R3 R8 row %0d pin_out", i), pin_out, v_exp);
            read_byte(1'b1, rv);
            check($sformatf("R6 R4 row %0d latch read", i), rv, v_exp);
            read_byte(1'b0, rv);
            check($sformatf("R5 row %0d pin read", i), rv, v_exp & v_pins);
        end

        // R9 busy window and dropped request; latch is 80h
        @(negedge clk);
        pin_in = 8'hFF;
        bus_op = 3'd2; bus_addr = 8'h80;
        @(negedge clk);
        check("R9 busy after accept", {7'd0, bus_busy}, 8'h01);
        check("R9 pin_out held", pin_out, 8'h80);
        bus_op = 3'd3; bus_addr = 8'h87;
        @(negedge clk);
        check("R9 busy second cycle", {7'd0, bus_busy}, 8'h01);
        check("R9 pin_out held 2", pin_out, 8'h80);
        bus_op = 3'd0;
        @(negedge clk);
        check("R9 busy cleared", {7'd0, bus_busy}, 8'h00);
        check("R3 R9 pin_out after commit", pin_out, 8'h81);
        repeat (3) @(negedge clk);
        check("R9 request during busy dropped", pin_out, 8'h81);

        // R5 synchronizer latency
        run_op(3'd1, 8'h80, 8'hFF);
        bus_addr = 8'h80; bus_rd_latch = 1'b0;
        pin_in = 8'h00;
        @(negedge clk);
        #1; check("R5 after one edge", bus_rdata, 8'hFF);
        @(negedge clk);
        #1; check("R5 after two edges", bus_rdata, 8'h00);

        // R4 complement with all pins low keeps latch
        run_op(3'd4, 8'h87, 8'h00);
        check("R4 latch kept under low pins", pin_out, 8'h7F);

        // R7 bit reads, pins low, latch 7Fh
        bus_addr = 8'h87; bus_rd_latch = 1'b1; #1;
        check("R7 latch bit 7", {7'd0, bus_rbit}, 8'h00);
        bus_addr = 8'h86; #1;
        check("R7 latch bit 6", {7'd0, bus_rbit}, 8'h01);
        check("R8 byte read at bit address", bus_rdata, 8'h00);
        bus_rd_latch = 1'b0; #1;
        check("R7 pin bit 6", {7'd0, bus_rbit}, 8'h00);

        // R8 miss
        bus_addr = 8'h90; bus_rd_latch = 1'b1; #1;
        check("R8 hit on miss", {7'd0, bus_hit}, 8'h00);
        check("R8 rdata on miss", bus_rdata, 8'h00);
        bus_addr = 8'h85; #1;
        check("R8 hit in window", {7'd0, bus_hit}, 8'h01);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule